// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Add Unit

This unit computes `±(a × b) ± c` on IEEE binary16 operands with exactly one rounding step. It is intended for a scalar floating-point pipeline whose register file holds 64-bit entries. Each operand arrives as a full 64-bit register value. The unit checks that the upper bits hold a valid box, substitutes the canonical quiet NaN where they do not, and returns its 16-bit result boxed back into 64 bits.

A 2-bit variant selector picks the signs: plain multiply-add, multiply-subtract, negated multiply-subtract or negated multiply-add. A 3-bit rounding-mode field comes from the instruction. One reserved value of that field defers to a dynamic mode supplied from the control/status side. The unit forms the product and the addend as exact fixed-point magnitudes and sums them exactly. It then rounds once, and reports the five IEEE exception flags.

The arithmetic is purely combinational. A single register stage holds the result, the flags and the illegal-mode indication, so every accepted operation appears one cycle after it is presented.

Top module: `hfma_unit`

## Requirements
- R1: `valid_o` is high in exactly the cycle after each cycle in which `valid_i` is high, and low otherwise.
- R2: The variant selects the signs. `variant_i` = 00 gives a×b+c. 01 gives a×b−c (addend negated). 10 gives −(a×b)+c (product negated). 11 gives −(a×b)−c (both negated).
- R3: An operand whose bits [63:16] are not all ones is treated as the quiet NaN 16'h7E00.
- R4: Every non-illegal result has bits [63:16] set to all ones, with the binary16 value in bits [15:0].
- R5: Rounding-mode encoding is 000 nearest-even, 001 toward zero, 010 down, 011 up and 100 nearest-ties-away. The value 111 selects `dyn_rm_i`, which uses the same encoding.
- R6: The product is not rounded before the addition. Only the final sum is rounded to binary16, so (1+2^-10)² − 1 yields 2^-9 with the inexact flag set.
- R7: Any NaN result is 16'h7E00. The invalid flag is raised by a signaling NaN input, by infinity times zero, and by infinities of opposite sign meeting in the sum. An infinite operand otherwise yields a correctly signed infinity with no flags.
- R8: On overflow the overflow and inexact flags are set. The result is infinity under nearest modes, the largest finite value (16'h7BFF magnitude) under toward-zero, and direction-dependent under up and down.
- R9: Subnormal inputs and outputs are exact where representable. The underflow flag is set when the unrounded result is below 2^-14 and the result is inexact.
- R10: An exact-zero sum of opposite-signed terms is +0, except in round-down mode, where it is −0.
- R11: `flags_o` bit 4 is invalid, bit 3 divide-by-zero (always 0), bit 2 overflow, bit 1 underflow and bit 0 inexact.
- R12: A field value of 101 or 110, or 111 with a dynamic mode of 101 to 111, raises `illegal_o` with `result_o` and `flags_o` both zero.
- R13: While `rst_ni` is low, `valid_o`, `illegal_o`, `result_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation presented this cycle |
| op_a_i | input | 64 | Multiplicand register value |
| op_b_i | input | 64 | Multiplier register value |
| op_c_i | input | 64 | Addend register value |
| variant_i | input | 2 | Sign variant selector |
| rm_i | input | 3 | Instruction rounding-mode field |
| dyn_rm_i | input | 3 | Dynamic rounding mode |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Boxed binary16 result |
| flags_o | output | 5 | Exception flags |
| illegal_o | output | 1 | Reserved rounding mode seen |

## Verification
Small integer operands are run through all four variants. Because each sign combination gives a distinct value (7, 5, −5, −7), a swapped negation cannot go unnoticed. Halfway cases near 1.0 and near the smallest subnormal are run under each rounding mode; they separate tie-to-even from ties-away and directed rounding, and expose any tininess or sticky-bit fault. The product (1+2^-10)² minus one gives an exact result only if the product was rounded first, so it separates a fused datapath from a chained one. NaN, infinity, cancellation and overflow inputs, together with partly boxed operands and reserved mode values, cover the special-case priority and the sign of zero.

// File: rtl/hfma_pkg.sv
package hfma_pkg;
  localparam int unsigned EXP_W = 5;
  localparam int unsigned MAN_W = 10;
  localparam int unsigned HW    = 1 + EXP_W + MAN_W;
  localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [HW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [2:0] {
    RM_RNE = 3'b000,
    RM_RTZ = 3'b001,
    RM_RDN = 3'b010,
    RM_RUP = 3'b011,
    RM_RMM = 3'b100,
    RM_DYN = 3'b111
  } rm_e;

  typedef struct packed {
    logic nv;
    logic dz;
    logic of;
    logic uf;
    logic nx;
  } fflags_t;
endpackage

// File: rtl/hfma_unbox.sv
module hfma_unbox
  import hfma_pkg::*;
#(
  parameter int unsigned FLEN = 64
) (
  input  logic [FLEN-1:0] reg_i,
  output logic [HW-1:0]   val_o
);
  assign val_o = (&reg_i[FLEN-1:HW]) ? reg_i[HW-1:0] : QNAN;
endmodule

// File: rtl/hfma_rm_sel.sv
module hfma_rm_sel
  import hfma_pkg::*;
(
  input  logic [2:0] rm_i,
  input  logic [2:0] dyn_i,
  output rm_e        rm_o,
  output logic       bad_o
);
  logic [2:0] eff;
  assign eff   = (rm_i == RM_DYN) ? dyn_i : rm_i;
  assign bad_o = (eff == 3'b101) || (eff == 3'b110) || (eff == 3'b111);
  assign rm_o  = rm_e'(eff);
endmodule

// File: rtl/hfma_core.sv
module hfma_core
  import hfma_pkg::*;
(
  input  logic [HW-1:0] a_i,
  input  logic [HW-1:0] b_i,
  input  logic [HW-1:0] c_i,
  input  logic          neg_prod_i,
  input  logic          neg_add_i,
  input  rm_e           rm_i,
  output logic [HW-1:0] res_o,
  output fflags_t       flags_o
);
  localparam int unsigned SIG_W = MAN_W + 1;
  localparam int unsigned EMAX  = (1 << EXP_W) - 2;
  localparam int unsigned ACC_W = 2 * SIG_W + 2 * EMAX - 1;   // exact sum, lsb = 2^-(2*SUB_Q)
  localparam int unsigned SUB_Q = BIAS + MAN_W - 1;           // bit weight of smallest subnormal
  localparam int unsigned ENC_W = EXP_W + MAN_W + 2;
  localparam int unsigned LZ_W  = $clog2(ACC_W);
  localparam logic [ENC_W-1:0] INF_ENC = ENC_W'(((1 << EXP_W) - 1) << MAN_W);

  logic [HW-1:0]    op [3];
  logic [EXP_W-1:0] ex [3];
  logic [EXP_W-1:0] ee [3];
  logic [SIG_W-1:0] sig [3];
  logic [2:0]       is_inf, is_nan, is_snan, is_zero;

  assign op[0] = a_i;
  assign op[1] = b_i;
  assign op[2] = c_i;

  for (genvar i = 0; i < 3; i++) begin : g_dec
    assign ex[i]      = op[i][HW-2:MAN_W];
    assign ee[i]      = (ex[i] == '0) ? EXP_W'(1) : ex[i];
    assign sig[i]     = {ex[i] != '0, op[i][MAN_W-1:0]};
    assign is_inf[i]  = (&ex[i]) && (op[i][MAN_W-1:0] == '0);
    assign is_nan[i]  = (&ex[i]) && (op[i][MAN_W-1:0] != '0);
    assign is_snan[i] = is_nan[i] && !op[i][MAN_W-1];
    assign is_zero[i] = (ex[i] == '0) && (op[i][MAN_W-1:0] == '0);
  end

  logic sp, sc;
  assign sp = a_i[HW-1] ^ b_i[HW-1] ^ neg_prod_i;
  assign sc = c_i[HW-1] ^ neg_add_i;

  // exact fixed-point magnitudes of product and addend
  logic [2*SIG_W-1:0] prod;
  logic [EXP_W:0]     pshift, cshift;
  logic [ACC_W-1:0]   mp, mc, mag;
  logic               sgn;

  assign prod   = sig[0] * sig[1];
  assign pshift = {1'b0, ee[0]} + {1'b0, ee[1]} - (EXP_W+1)'(2);
  assign cshift = {1'b0, ee[2]} + (EXP_W+1)'(SUB_Q - 1);
  assign mp     = {{(ACC_W-2*SIG_W){1'b0}}, prod} << pshift;
  assign mc     = {{(ACC_W-SIG_W){1'b0}}, sig[2]} << cshift;

  always_comb begin
    if (sp == sc) begin
      mag = mp + mc;
      sgn = sp;
    end else if (mp >= mc) begin
      mag = mp - mc;
      sgn = sp;
    end else begin
      mag = mc - mp;
      sgn = sc;
    end
  end

  // normalize and round once
  logic [LZ_W-1:0]  lead, q, qm1;
  logic [SIG_W-1:0] kept;
  logic [SIG_W:0]   kept_r;
  logic [ENC_W-1:0] enc;
  logic             rnd, st, inc, tiny, ovf;

  always_comb begin
    lead = '0;
    for (int i = 0; i < ACC_W; i++) if (mag[i]) lead = LZ_W'(i);
  end

  assign q    = (lead >= LZ_W'(SUB_Q + MAN_W)) ? lead - LZ_W'(MAN_W) : LZ_W'(SUB_Q);
  assign qm1  = q - LZ_W'(1);
  assign kept = SIG_W'(mag >> q);
  assign rnd  = mag[qm1];
  assign st   = |(mag & ((ACC_W'(1) << qm1) - ACC_W'(1)));
  assign tiny = lead < LZ_W'(SUB_Q + MAN_W);

  always_comb begin
    case (rm_i)
      RM_RNE:  inc = rnd & (st | kept[0]);
      RM_RDN:  inc = sgn & (rnd | st);
      RM_RUP:  inc = !sgn & (rnd | st);
      RM_RMM:  inc = rnd;
      default: inc = 1'b0;
    endcase
  end

  assign kept_r = {1'b0, kept} + (SIG_W+1)'(inc);
  assign enc    = (ENC_W'(q - LZ_W'(SUB_Q)) << MAN_W) + ENC_W'(kept_r);
  assign ovf    = enc >= INF_ENC;

  // special-case priority
  logic prod_inf, invalid, to_inf;
  assign prod_inf = is_inf[0] | is_inf[1];
  assign invalid  = (|is_snan) | (is_inf[0] & is_zero[1]) | (is_zero[0] & is_inf[1])
                  | (prod_inf & is_inf[2] & (sp != sc));
  assign to_inf   = (rm_i == RM_RNE) || (rm_i == RM_RMM) ||
                    ((rm_i == RM_RUP) && !sgn) || ((rm_i == RM_RDN) && sgn);

  always_comb begin
    flags_o = '0;
    if ((|is_nan) || invalid) begin
      res_o      = QNAN;
      flags_o.nv = invalid;
    end else if (prod_inf) begin
      res_o = {sp, INF_ENC[HW-2:0]};
    end else if (is_inf[2]) begin
      res_o = {sc, INF_ENC[HW-2:0]};
    end else if (mag == '0) begin
      res_o = {(sp == sc) ? sp : (rm_i == RM_RDN), {(HW-1){1'b0}}};
    end else if (ovf) begin
      res_o      = to_inf ? {sgn, INF_ENC[HW-2:0]} : {sgn, INF_ENC[HW-2:0] - (HW-1)'(1)};
      flags_o.of = 1'b1;
      flags_o.nx = 1'b1;
    end else begin
      res_o      = {sgn, enc[HW-2:0]};
      flags_o.nx = rnd | st;
      flags_o.uf = tiny & (rnd | st);
    end
  end
endmodule

// File: rtl/hfma_unit.sv
module hfma_unit
  import hfma_pkg::*;
#(
  parameter int unsigned FLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [FLEN-1:0] op_a_i,
  input  logic [FLEN-1:0] op_b_i,
  input  logic [FLEN-1:0] op_c_i,
  input  logic [1:0]      variant_i,
  input  logic [2:0]      rm_i,
  input  logic [2:0]      dyn_rm_i,
  output logic            valid_o,
  output logic [FLEN-1:0] result_o,
  output logic [4:0]      flags_o,
  output logic            illegal_o
);
  logic [FLEN-1:0] regs [3];
  logic [HW-1:0]   vals [3];
  assign regs[0] = op_a_i;
  assign regs[1] = op_b_i;
  assign regs[2] = op_c_i;

  for (genvar i = 0; i < 3; i++) begin : g_unbox
    hfma_unbox #(.FLEN(FLEN)) u_unbox (.reg_i(regs[i]), .val_o(vals[i]));
  end

  rm_e     rm_eff;
  logic    rm_bad;
  logic [HW-1:0] res;
  fflags_t fl;

  hfma_rm_sel u_rm (.rm_i(rm_i), .dyn_i(dyn_rm_i), .rm_o(rm_eff), .bad_o(rm_bad));

  hfma_core u_core (
    .a_i(vals[0]), .b_i(vals[1]), .c_i(vals[2]),
    .neg_prod_i(variant_i[1]), .neg_add_i(variant_i[0]),
    .rm_i(rm_eff), .res_o(res), .flags_o(fl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= rm_bad;
        result_o  <= rm_bad ? '0 : {{(FLEN-HW){1'b1}}, res};
        flags_o   <= rm_bad ? '0 : fl;
      end
    end
  end
endmodule

// File: rtl/hfma_unit_chk.sv
module hfma_unit_chk #(
  parameter int unsigned FLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      rm_i,
  input logic            valid_o,
  input logic [FLEN-1:0] result_o,
  input logic [4:0]      flags_o,
  input logic            illegal_o
);
  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r4_boxed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |-> (&result_o[FLEN-1:16]));
  a_r7_canon_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (&result_o[14:10]) && (result_o[9:0] != 10'd0)) |-> (result_o[15:0] == 16'h7E00));
  a_r8_of_nx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[2]) |-> flags_o[0]);
  a_r9_uf_nx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flags_o[1]) |-> flags_o[0]);
  a_r11_no_dz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !flags_o[3]);
  a_r12_reserved_rm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (rm_i == 3'b101 || rm_i == 3'b110)) |=> illegal_o);
  a_r12_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (result_o == '0 && flags_o == 5'd0));
endmodule

bind hfma_unit hfma_unit_chk #(.FLEN(FLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .rm_i(rm_i),
  .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o), .illegal_o(illegal_o)
);

// File: tb/hfma_unit_tb.sv
module hfma_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] op_a_i = '0, op_b_i = '0, op_c_i = '0;
  logic [1:0]  variant_i = '0;
  logic [2:0]  rm_i = '0, dyn_rm_i = '0;
  logic        valid_o, illegal_o;
  logic [63:0] result_o;
  logic [4:0]  flags_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  hfma_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i),
    .variant_i(variant_i), .rm_i(rm_i), .dyn_rm_i(dyn_rm_i),
    .valid_o(valid_o), .result_o(result_o), .flags_o(flags_o), .illegal_o(illegal_o)
  );

  localparam logic [47:0] BX = '1;

  typedef struct packed {
    logic [63:0] a, b, c;
    logic [1:0]  v;
    logic [2:0]  rm, dyn;
    logic [15:0] res;
    logic [4:0]  fl;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{{BX,16'h4000}, {BX,16'h4200}, {BX,16'h3C00}, 2'b00, 3'd0, 3'd0, 16'h4700, 5'b00000, 1'b0, 4'd2},  // R2 plain
    '{{BX,16'h4000}, {BX,16'h4200}, {BX,16'h3C00}, 2'b01, 3'd0, 3'd0, 16'h4500, 5'b00000, 1'b0, 4'd2},  // R2 msub
    '{{BX,16'h4000}, {BX,16'h4200}, {BX,16'h3C00}, 2'b10, 3'd0, 3'd0, 16'hC500, 5'b00000, 1'b0, 4'd2},  // R2 nmsub
    '{{BX,16'h4000}, {BX,16'h4200}, {BX,16'h3C00}, 2'b11, 3'd0, 3'd0, 16'hC700, 5'b00000, 1'b0, 4'd2},  // R2 nmadd
    '{64'h0000_0000_0000_4000, {BX,16'h4200}, {BX,16'h3C00}, 2'b00, 3'd0, 3'd0, 16'h7E00, 5'b00000, 1'b0, 4'd3}, // R3
    '{{BX,16'h4000}, 64'hFFFF_FFFF_FFFE_3C00, {BX,16'h3C00}, 2'b00, 3'd0, 3'd0, 16'h7E00, 5'b00000, 1'b0, 4'd3}, // R3
    '{{BX,16'h7C01}, {BX,16'h3C00}, {BX,16'h0000}, 2'b00, 3'd0, 3'd0, 16'h7E00, 5'b10000, 1'b0, 4'd7},  // R7 sNaN
    '{{BX,16'h7C00}, {BX,16'h0000}, {BX,16'h3C00}, 2'b00, 3'd0, 3'd0, 16'h7E00, 5'b10000, 1'b0, 4'd7},  // R7 inf*0
    '{{BX,16'h7C00}, {BX,16'h3C00}, {BX,16'hFC00}, 2'b00, 3'd0, 3'd0, 16'h7E00, 5'b10000, 1'b0, 4'd7},  // R7 inf-inf
    '{{BX,16'h7C00}, {BX,16'h3C00}, {BX,16'h3C00}, 2'b00, 3'd0, 3'd0, 16'h7C00, 5'b00000, 1'b0, 4'd7},  // R7 inf
    '{{BX,16'h3C00}, {BX,16'h3C00}, {BX,16'h3C00}, 2'b01, 3'd0, 3'd0, 16'h0000, 5'b00000, 1'b0, 4'd10}, // R10 +0
    '{{BX,16'h3C00}, {BX,16'h3C00}, {BX,16'h3C00}, 2'b01, 3'd2, 3'd0, 16'h8000, 5'b00000, 1'b0, 4'd10}, // R10 -0
    '{{BX,16'h3C00}, {BX,16'h3C00}, {BX,16'h3C00}, 2'b01, 3'd7, 3'd2, 16'h8000, 5'b00000, 1'b0, 4'd5},  // R5 dynamic
    '{{BX,16'h4000}, {BX,16'h4200}, {BX,16'h3C00}, 2'b00, 3'd5, 3'd0, 16'h0000, 5'b00000, 1'b1, 4'd12}, // R12
    '{{BX,16'h4000}, {BX,16'h4200}, {BX,16'h3C00}, 2'b00, 3'd7, 3'd6, 16'h0000, 5'b00000, 1'b1, 4'd12}, // R12
    '{{BX,16'h7BFF}, {BX,16'h4000}, {BX,16'h0000}, 2'b00, 3'd0, 3'd0, 16'h7C00, 5'b00101, 1'b0, 4'd8},  // R8
    '{{BX,16'h7BFF}, {BX,16'h4000}, {BX,16'h0000}, 2'b00, 3'd1, 3'd0, 16'h7BFF, 5'b00101, 1'b0, 4'd8},  // R8
    '{{BX,16'h7BFF}, {BX,16'h4000}, {BX,16'h0000}, 2'b11, 3'd3, 3'd0, 16'hFBFF, 5'b00101, 1'b0, 4'd8},  // R8
    '{{BX,16'h7BFF}, {BX,16'h4000}, {BX,16'h0000}, 2'b11, 3'd2, 3'd0, 16'hFC00, 5'b00101, 1'b0, 4'd8},  // R8
    '{{BX,16'h3C00}, {BX,16'h3C00}, {BX,16'h1000}, 2'b00, 3'd0, 3'd0, 16'h3C00, 5'b00001, 1'b0, 4'd5},  // R5 tie even
    '{{BX,16'h3C00}, {BX,16'h3C00}, {BX,16'h1000}, 2'b00, 3'd4, 3'd0, 16'h3C01, 5'b00001, 1'b0, 4'd5},  // R5 ties away
    '{{BX,16'h3C00}, {BX,16'h3C00}, {BX,16'h1000}, 2'b00, 3'd1, 3'd0, 16'h3C00, 5'b00001, 1'b0, 4'd11}, // R11 nx bit0
    '{{BX,16'h3C01}, {BX,16'h3C01}, {BX,16'hBC00}, 2'b00, 3'd0, 3'd0, 16'h1800, 5'b00001, 1'b0, 4'd6},  // R6
    '{{BX,16'h3C01}, {BX,16'h3C01}, {BX,16'hBC00}, 2'b00, 3'd3, 3'd0, 16'h1801, 5'b00001, 1'b0, 4'd6},  // R6
    '{{BX,16'h0001}, {BX,16'h3C00}, {BX,16'h0000}, 2'b00, 3'd0, 3'd0, 16'h0001, 5'b00000, 1'b0, 4'd9},  // R9
    '{{BX,16'h0001}, {BX,16'h3800}, {BX,16'h0000}, 2'b00, 3'd0, 3'd0, 16'h0000, 5'b00011, 1'b0, 4'd9},  // R9
    '{{BX,16'h0001}, {BX,16'h3800}, {BX,16'h0000}, 2'b00, 3'd3, 3'd0, 16'h0001, 5'b00011, 1'b0, 4'd9},  // R9
    '{{BX,16'h0001}, {BX,16'h6400}, {BX,16'h0000}, 2'b00, 3'd0, 3'd0, 16'h0400, 5'b00000, 1'b0, 4'd9}   // R9
  };

  task automatic chk(input bit ok, input int req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    logic [63:0] er;
    @(negedge clk_i);
    op_a_i = v.a; op_b_i = v.b; op_c_i = v.c;
    variant_i = v.v; rm_i = v.rm; dyn_rm_i = v.dyn;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    er = v.ill ? 64'd0 : {BX, v.res};  // R4 box expected on every legal result
    chk(valid_o && result_o == er && illegal_o == v.ill, int'(v.req),
        {illegal_o, result_o[62:0]}, {v.ill, er[62:0]});
    chk(flags_o == v.fl, int'(v.req), 64'(flags_o), 64'(v.fl));
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R13 reset state
    chk(!valid_o && !illegal_o && result_o == '0 && flags_o == '0, 13,
        {valid_o, illegal_o, flags_o, result_o[56:0]}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run(VECS[i]);

    // R1: one-cycle pulse in gives one-cycle pulse out
    @(negedge clk_i);
    op_a_i = {BX,16'h4000}; op_b_i = {BX,16'h4200}; op_c_i = {BX,16'h3C00};
    variant_i = 2'b00; rm_i = 3'd0; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o == 1'b1, 1, 64'(valid_o), 64'd1);
    @(negedge clk_i);
    chk(valid_o == 1'b0, 1, 64'(valid_o), 64'd0);

    // R13: asynchronous reset clears held outputs
    run(VECS[0]);
    rst_ni = 1'b0;
    #1;
    chk(!valid_o && !illegal_o && result_o == '0 && flags_o == '0, 13,
        {valid_o, illegal_o, flags_o, result_o[56:0]}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule